// File: doc/BRIEF.md
# Comparator Output Conditioner

This block takes the single-bit output of an analog comparator and turns it into a clean digital signal. The bit first passes an optional synchronizer and an optional inverter. It then passes a blanking stage that can freeze the signal for a programmable number of clocks after a selected edge or an external trigger pulse. Last comes a glitch filter, which passes a new level only after the level has stayed the same for a programmable number of consecutive clocks.

The filter can run all the time. It can also run only while the slope generator reports that a given reference value is driving the DAC. At all other times the filter is bypassed. The block drives the conditioned bit and two one-cycle strobes that mark its rising and falling transitions. Software or a neighbouring control block holds every setting on static configuration inputs. The trigger pulse and the reference status are live signals.

Top module: `cmp_conditioner`

## Requirements
- R1: While rst_n is low and on the first cycle after reset, cmp_out, rise_evt and fall_evt are all 0.
- R2: With invert_en = 1 the conditioned level is the complement of cmp_raw. With invert_en = 0 it equals cmp_raw.
- R3: With sync_en = 0, a change of cmp_raw reaches cmp_out 2 clock edges later when blanking and filtering are idle. With sync_en = 1 a 2-stage synchronizer adds 2 edges, for 4 in total.
- R4: blank_mode selects the edge that starts a blanking window: 0 = none, 1 = low-to-high, 2 = high-to-low, 3 = either. The edge is taken on the inverted and synchronized signal. On the triggering edge and for blank_len clock edges in total, the blanking stage holds the level it had before the edge.
- R5: blank_len = 0 disables every blanking window. Triggers that arrive while a window is open are ignored and do not extend it.
- R6: With ext_blank_en = 1 a high ext_blank_trig starts a window exactly like a selected edge. With ext_blank_en = 0, ext_blank_trig has no effect on cmp_out.
- R7: When the filter is active, cmp_out takes a new level only after the blanked level has differed from cmp_out on N consecutive edges. N = filt_win + 2 for codes 0 to 14, and N = 32 for code 15. A shorter glitch resets the count and leaves cmp_out unchanged.
- R8: The filter is active when filt_en = 1 and one of these holds: filt_ctrl = 0 or 3; filt_ctrl = 1 with ref_sel = 0 (reference 1 on the DAC); filt_ctrl = 2 with ref_sel = 1 (reference 2 on the DAC). When the filter is inactive, cmp_out equals the blanked level delayed by one register.
- R9: rise_evt is high for exactly the cycle in which cmp_out has just gone from 0 to 1. fall_evt is high for exactly the cycle in which it has gone from 1 to 0. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_raw | input | 1 | Raw comparator output, possibly asynchronous |
| sync_en | input | 1 | 1 = route the bit through the synchronizer |
| invert_en | input | 1 | 1 = invert the comparator bit |
| blank_mode | input | 2 | Edge that starts blanking (0 none, 1 rise, 2 fall, 3 both) |
| blank_len | input | 7 | Blanking window length in clock cycles |
| ext_blank_en | input | 1 | 1 = ext_blank_trig may start a window |
| ext_blank_trig | input | 1 | External blanking trigger, sampled each clock |
| filt_en | input | 1 | 1 = glitch filter enabled |
| filt_win | input | 4 | Stability window code |
| filt_ctrl | input | 2 | Filter gating (0/3 always, 1 ref 1 only, 2 ref 2 only) |
| ref_sel | input | 1 | Reference on the DAC: 0 = reference 1, 1 = reference 2 |
| cmp_out | output | 1 | Conditioned comparator bit |
| rise_evt | output | 1 | One-cycle strobe on a 0-to-1 change of cmp_out |
| fall_evt | output | 1 | One-cycle strobe on a 1-to-0 change of cmp_out |

## Verification
On every cycle the assertions check these properties:
- An open blanking window freezes the blanked level.
- An idle, zero-length blanking stage follows its input one edge later.
- The filter keeps its output when input and output agree.
- A bypassed filter copies its input, and the filter count stays within the longest window.
- The strobes match actual transitions of cmp_out and never overlap.

The exact number of cycles a window or a filter count lasts, the window-code decoding, the edge selection, the external trigger and its enable, and the latency added by the synchronizer can only be shown by the bench. It compares the ports against its own cycle model while it sweeps random configurations and runs directed glitch and latency cases.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;

    typedef enum logic [1:0] {
        BLK_OFF  = 2'd0,
        BLK_RISE = 2'd1,
        BLK_FALL = 2'd2,
        BLK_BOTH = 2'd3
    } blank_mode_e;

    typedef enum logic [1:0] {
        FC_ALWAYS     = 2'd0,
        FC_REF1       = 2'd1,
        FC_REF2       = 2'd2,
        FC_ALWAYS_ALT = 2'd3
    } filt_ctrl_e;

endpackage

// File: rtl/cmpc_front.sv
module cmpc_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic sync_en_i,
    input  logic invert_en_i,
    output logic level_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
    } front_st_t;

    front_st_t st_d, st_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_comb begin
                st_d       = st_q;
                st_d.chain = raw_i;
            end
        end else begin : g_many
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[SYNC_STAGES-2:0], raw_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = (sync_en_i ? st_q.chain[SYNC_STAGES-1] : raw_i) ^ invert_en_i;

endmodule

// File: rtl/cmpc_blank.sv
module cmpc_blank
    import cmpc_pkg::*;
#(
    parameter int BLANK_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               level_i,
    input  blank_mode_e        mode_i,
    input  logic [BLANK_W-1:0] len_i,
    input  logic               ext_en_i,
    input  logic               ext_trig_i,
    output logic               level_o
);
    typedef struct packed {
        logic               prev;
        logic               hold;
        logic [BLANK_W-1:0] cnt;
    } blank_st_t;

    blank_st_t st_d, st_q;
    logic      edge_up, edge_dn, trig, win_open;

    always_comb begin
        edge_up  = level_i & ~st_q.prev;
        edge_dn  = ~level_i & st_q.prev;
        trig     = (edge_up & (mode_i == BLK_RISE || mode_i == BLK_BOTH))
                 | (edge_dn & (mode_i == BLK_FALL || mode_i == BLK_BOTH))
                 | (ext_en_i & ext_trig_i);
        win_open = (st_q.cnt != '0);

        st_d      = st_q;
        st_d.prev = level_i;
        if (win_open) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (trig && (len_i != '0)) begin
            st_d.cnt = len_i - 1'b1;
        end else begin
            st_d.hold = level_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.hold;

    // R4: an open window freezes the blanked level
    p_window_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |=> $stable(st_q.hold));

    // R5: with no window and zero length the stage follows its input
    p_zero_len_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && len_i == '0) |=> (st_q.hold == $past(level_i)));

endmodule

// File: rtl/cmpc_filter.sv
module cmpc_filter
    import cmpc_pkg::*;
#(
    parameter int WIN_W       = 4,
    parameter int LONG_STABLE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_i,
    input  logic             en_i,
    input  logic [WIN_W-1:0] win_i,
    input  filt_ctrl_e       ctrl_i,
    input  logic             ref_sel_i,
    output logic             level_o,
    output logic             rise_o,
    output logic             fall_o
);
    localparam int CNT_W = $clog2(LONG_STABLE + 1);
    localparam logic [WIN_W-1:0] WIN_MAX = {WIN_W{1'b1}};

    typedef struct packed {
        logic             lvl;
        logic             rise;
        logic             fall;
        logic [CNT_W-1:0] cnt;
    } filt_st_t;

    filt_st_t         st_d, st_q;
    logic             active;
    logic [CNT_W-1:0] need;

    always_comb begin
        unique case (ctrl_i)
            FC_REF1: active = en_i & ~ref_sel_i;
            FC_REF2: active = en_i & ref_sel_i;
            default: active = en_i;
        endcase
        need = (win_i == WIN_MAX) ? CNT_W'(LONG_STABLE) : CNT_W'(win_i) + CNT_W'(2);

        st_d = st_q;
        if (!active) begin
            st_d.lvl = level_i;
            st_d.cnt = '0;
        end else if (level_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == need - 1'b1) begin
            st_d.lvl = level_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.rise = st_d.lvl & ~st_q.lvl;
        st_d.fall = ~st_d.lvl & st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.lvl;
    assign rise_o  = st_q.rise;
    assign fall_o  = st_q.fall;

    // R8: a bypassed filter is one register stage
    p_bypass_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.lvl == $past(level_i)));

    // R7: agreement between input and output keeps the output
    p_agree_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && level_i == st_q.lvl) |=> $stable(st_q.lvl));

    // R7: the stability count never reaches the longest window
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(LONG_STABLE));

endmodule

// File: rtl/cmp_conditioner.sv
module cmp_conditioner
    import cmpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BLANK_W     = 7,
    parameter int WIN_W       = 4,
    parameter int LONG_STABLE = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_raw,
    input  logic               sync_en,
    input  logic               invert_en,
    input  logic [1:0]         blank_mode,
    input  logic [BLANK_W-1:0] blank_len,
    input  logic               ext_blank_en,
    input  logic               ext_blank_trig,
    input  logic               filt_en,
    input  logic [WIN_W-1:0]   filt_win,
    input  logic [1:0]         filt_ctrl,
    input  logic               ref_sel,
    output logic               cmp_out,
    output logic               rise_evt,
    output logic               fall_evt
);
    logic front_lvl, blank_lvl;

    cmpc_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (cmp_raw),
        .sync_en_i  (sync_en),
        .invert_en_i(invert_en),
        .level_o    (front_lvl)
    );

    cmpc_blank #(.BLANK_W(BLANK_W)) blank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (front_lvl),
        .mode_i    (blank_mode_e'(blank_mode)),
        .len_i     (blank_len),
        .ext_en_i  (ext_blank_en),
        .ext_trig_i(ext_blank_trig),
        .level_o   (blank_lvl)
    );

    cmpc_filter #(.WIN_W(WIN_W), .LONG_STABLE(LONG_STABLE)) filter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (blank_lvl),
        .en_i     (filt_en),
        .win_i    (filt_win),
        .ctrl_i   (filt_ctrl_e'(filt_ctrl)),
        .ref_sel_i(ref_sel),
        .level_o  (cmp_out),
        .rise_o   (rise_evt),
        .fall_o   (fall_evt)
    );

    // R9: strobes never overlap
    p_evt_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_evt && fall_evt));

    // R9: a rise strobe marks a real 0-to-1 change
    p_rise_real_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |-> (cmp_out && !$past(cmp_out)));

    // R9: a fall strobe marks a real 1-to-0 change
    p_fall_real_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |-> (!cmp_out && $past(cmp_out)));

endmodule

// File: tb/cmp_conditioner_tb_top.sv
module cmp_conditioner_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw = 1'b0, sync_en = 1'b0, invert_en = 1'b0;
    logic [1:0] blank_mode = 2'd0;
    logic [6:0] blank_len = 7'd0;
    logic       ext_blank_en = 1'b0, ext_blank_trig = 1'b0;
    logic       filt_en = 1'b0;
    logic [3:0] filt_win = 4'd0;
    logic [1:0] filt_ctrl = 2'd0;
    logic       ref_sel = 1'b0;
    logic       cmp_out, rise_evt, fall_evt;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    cmp_on   = 1'b0;

    always #5 clk = ~clk;

    cmp_conditioner dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .sync_en(sync_en),
        .invert_en(invert_en), .blank_mode(blank_mode), .blank_len(blank_len),
        .ext_blank_en(ext_blank_en), .ext_blank_trig(ext_blank_trig),
        .filt_en(filt_en), .filt_win(filt_win), .filt_ctrl(filt_ctrl),
        .ref_sel(ref_sel), .cmp_out(cmp_out), .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    // reference model state
    logic       m_s1, m_s2, m_prev, m_hold, m_out, m_rise, m_fall;
    int         m_bcnt, m_fcnt;

    function automatic int need_cycles(logic [3:0] code);
        return (code == 4'hF) ? 32 : int'(code) + 2;
    endfunction

    function automatic bit filt_active(logic en, logic [1:0] ctl, logic rs);
        if (!en) return 1'b0;
        if (ctl == 2'd1) return !rs;
        if (ctl == 2'd2) return rs;
        return 1'b1;
    endfunction

    function automatic bit blank_trig(logic [1:0] md, logic now, logic prv, logic een, logic etr);
        return (md[0] && now && !prv) || (md[1] && !now && prv) || (een && etr);
    endfunction

    always @(posedge clk) begin
        logic fr, b_old, o_new;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_hold = 0; m_out = 0;
            m_rise = 0; m_fall = 0; m_bcnt = 0; m_fcnt = 0;
        end else begin
            fr    = (sync_en ? m_s2 : cmp_raw) ^ invert_en;
            b_old = m_hold;
            m_s2  = m_s1;
            m_s1  = cmp_raw;
            if (m_bcnt != 0) m_bcnt = m_bcnt - 1;
            else if (blank_trig(blank_mode, fr, m_prev, ext_blank_en, ext_blank_trig)
                     && blank_len != 0) m_bcnt = int'(blank_len) - 1;
            else m_hold = fr;
            m_prev = fr;
            o_new = m_out;
            if (!filt_active(filt_en, filt_ctrl, ref_sel)) begin
                o_new = b_old; m_fcnt = 0;
            end else if (b_old == m_out) m_fcnt = 0;
            else if (m_fcnt == need_cycles(filt_win) - 1) begin
                o_new = b_old; m_fcnt = 0;
            end else m_fcnt = m_fcnt + 1;
            m_rise = o_new && !m_out;
            m_fall = !o_new && m_out;
            m_out  = o_new;
        end
    end

    task automatic check(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            check(cur_req, "cmp_out", cmp_out, m_out);
            check(cur_req, "rise_evt", rise_evt, m_rise);
            check(cur_req, "fall_evt", fall_evt, m_fall);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet_cfg();
        sync_en = 0; invert_en = 0; blank_mode = 0; blank_len = 0;
        ext_blank_en = 0; ext_blank_trig = 0; filt_en = 0; filt_win = 0;
        filt_ctrl = 0; ref_sel = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        // R1 reset state
        cyc(3);
        check("R1", "cmp_out in reset", cmp_out, 1'b0);
        check("R1", "rise_evt in reset", rise_evt, 1'b0);
        check("R1", "fall_evt in reset", fall_evt, 1'b0);
        rst_n = 1;
        cyc(1);
        check("R1", "cmp_out after reset", cmp_out, 1'b0);
        cmp_on = 1;

        // R3 latency without synchronizer: 2 edges
        cur_req = "R3";
        cmp_raw = 1; cyc(1);
        check("R3", "no-sync edge 1", cmp_out, 1'b0);
        cyc(1);
        check("R3", "no-sync edge 2", cmp_out, 1'b1);
        check("R9", "rise strobe", rise_evt, 1'b1);
        cyc(1);
        check("R9", "rise strobe one cycle", rise_evt, 1'b0);
        // with synchronizer: 4 edges
        sync_en = 1; cyc(4);
        cmp_raw = 0; cyc(3);
        check("R3", "sync edge 3", cmp_out, 1'b1);
        cyc(1);
        check("R3", "sync edge 4", cmp_out, 1'b0);
        check("R9", "fall strobe", fall_evt, 1'b1);

        // R2 inversion
        cur_req = "R2";
        sync_en = 0; invert_en = 1; cyc(3);
        check("R2", "inverted low input", cmp_out, 1'b1);
        cmp_raw = 1; cyc(3);
        check("R2", "inverted high input", cmp_out, 1'b0);
        invert_en = 0; cyc(3);

        // R7 short glitch rejected by code 0 (2 cycles needed)
        cur_req = "R7";
        cmp_raw = 0; cyc(4);
        filt_en = 1; filt_win = 4'd0;
        cmp_raw = 1; cyc(1); cmp_raw = 0; cyc(4);
        check("R7", "one-cycle glitch filtered", cmp_out, 1'b0);
        cmp_raw = 1; cyc(4);
        check("R7", "two-cycle level passes", cmp_out, 1'b1);
        // code 15 needs 32
        filt_win = 4'hF; cmp_raw = 0; cyc(32);
        check("R7", "code 15 before 32 cycles", cmp_out, 1'b1);
        cyc(2);
        check("R7", "code 15 after 32 cycles", cmp_out, 1'b0);

        // R8 gating by reference
        cur_req = "R8";
        filt_win = 4'd10; filt_ctrl = 2'd2; ref_sel = 0;
        cmp_raw = 1; cyc(3);
        check("R8", "bypass when other ref on DAC", cmp_out, 1'b1);
        ref_sel = 1; cmp_raw = 0; cyc(4);
        check("R8", "filter holds when its ref on DAC", cmp_out, 1'b1);
        cyc(12);

        // R4 rising-edge blanking
        cur_req = "R4";
        quiet_cfg(); cmp_raw = 0; cyc(4);
        blank_mode = 2'd1; blank_len = 7'd6;
        cmp_raw = 1; cyc(1); cmp_raw = 0; cyc(1); cmp_raw = 1; cyc(3);
        check("R4", "held during window", cmp_out, 1'b0);
        cyc(6);
        check("R4", "released after window", cmp_out, 1'b1);

        // R6 external trigger disabled, then enabled
        cur_req = "R6";
        blank_mode = 0; blank_len = 7'd5; ext_blank_en = 0;
        ext_blank_trig = 1; cyc(1); ext_blank_trig = 0;
        cmp_raw = 0; cyc(3);
        check("R6", "disabled trigger ignored", cmp_out, 1'b0);
        ext_blank_en = 1; ext_blank_trig = 1; cyc(1); ext_blank_trig = 0;
        cmp_raw = 1; cyc(3);
        check("R6", "enabled trigger blanks", cmp_out, 1'b0);
        cyc(6);

        // R5 zero length disables blanking
        cur_req = "R5";
        blank_mode = 2'd3; blank_len = 0; cmp_raw = 0; cyc(2);
        check("R5", "zero length passes edge", cmp_out, 1'b0);
        cyc(2);

        // random sweep against the model
        for (int seg = 0; seg < 48; seg++) begin
            int tog;
            cur_req   = (seg % 2) ? "R7" : "R4";
            sync_en   = $urandom_range(0, 1);
            invert_en = $urandom_range(0, 1);
            blank_mode = 2'($urandom_range(0, 3));
            blank_len = 7'($urandom_range(0, 12));
            ext_blank_en = $urandom_range(0, 1);
            filt_en   = $urandom_range(0, 1);
            filt_win  = 4'($urandom_range(0, 15));
            filt_ctrl = 2'($urandom_range(0, 3));
            tog       = $urandom_range(3, 40);
            for (int k = 0; k < 140; k++) begin
                if ($urandom_range(0, 99) < tog) cmp_raw = ~cmp_raw;
                ext_blank_trig = ($urandom_range(0, 29) == 0);
                if ($urandom_range(0, 49) == 0) ref_sel = ~ref_sel;
                cyc(1);
            end
        end

        cmp_on = 0;
        cyc(1);
        summary();
        $finish;
    end

endmodule